// File: doc/BRIEF.md
# SPI Frame CRC Engine

This block keeps a running cyclic redundancy check over the data frames of a serial peripheral link, one accumulator for the words being sent and another for the words arriving. It sits beside the shift register. Each time the shifter finishes a frame it raises a strobe with the frame word, and the matching accumulator folds that word in, most significant bit first, using a programmable generator polynomial. A format input picks narrow (8-bit) or wide (16-bit) frames, and the check width follows it.

To close a message, control logic pulses a one-shot request. The data frame now in flight completes normally. The engine then marks the following frame as the check frame, and its transmit word is the current transmit accumulator. On the receive side, the word arriving during that check frame is compared against the local receive accumulator. A mismatch latches an error flag, which software clears by writing zero to it. When the enable input is low, both accumulators are held at zero.

Top module: `spi_crc_engine`

## Requirements
- R1: After reset the polynomial output `poly` is 0x0007; a cycle with `poly_wr` high loads `poly_wdata`, visible after that clock edge.
- R2: A `tx_done` strobe changes only `tx_crc` and a `rx_done` strobe changes only `rx_crc`; with no strobe both accumulators hold their value.
- R3: A frame update folds the data bits from the most significant bit down. For each bit, the feedback is the accumulator's top bit XOR the data bit; the accumulator shifts left by one with a zero entering; if the feedback is 1, the polynomial is XORed in.
- R4: With `frame_wide`=0 the fold is 8 bits wide. It uses only data bits [7:0] and polynomial bits [7:0], and accumulator bits [15:8] stay zero. With `frame_wide`=1 all 16 bits are used.
- R5: While `crc_en` is low, both accumulators are zero after the next clock edge, and strobes do not change them.
- R6: A `next_req` pulse (with `crc_en` high) sets `crc_next`. The next `tx_done` of a data frame then updates `tx_crc` and sets `crc_phase`. A `tx_done` while `crc_phase` is 1 does not change `tx_crc`.
- R7: The `tx_done` that ends the check frame (while `crc_phase` is 1) clears both `crc_phase` and `crc_next`.
- R8: A `rx_done` while `crc_phase` is 1 compares `rx_data` with `rx_crc` over the current frame width and leaves `rx_crc` unchanged. If they differ, `crc_err` becomes 1.
- R9: A cycle with `stat_wr` high and `stat_wdata`=0 clears `crc_err`, and with `stat_wdata`=1 it leaves `crc_err` unchanged. A mismatch in the same cycle as a clear sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_en | input | 1 | Check calculation enable; low clears both accumulators |
| frame_wide | input | 1 | 0: 8-bit frames, 1: 16-bit frames |
| poly_wr | input | 1 | Load strobe for the polynomial register |
| poly_wdata | input | 16 | Polynomial value to load |
| next_req | input | 1 | One-shot request to append the check word |
| tx_done | input | 1 | Transmit frame finished strobe |
| tx_data | input | 16 | Word of the finished transmit frame |
| rx_done | input | 1 | Receive frame finished strobe |
| rx_data | input | 16 | Word of the finished receive frame |
| stat_wr | input | 1 | Write strobe for the error flag |
| stat_wdata | input | 1 | Value written to the error flag (only 0 acts) |
| poly | output | 16 | Current polynomial |
| tx_crc | output | 16 | Transmit accumulator, also the check word to send |
| rx_crc | output | 16 | Receive accumulator |
| crc_next | output | 1 | Append request pending |
| crc_phase | output | 1 | The frame now in progress is the check frame |
| crc_err | output | 1 | Check mismatch flag |

## Verification
The properties assume that strobes last one cycle and that a new append request does not arrive in the same cycle as the `tx_done` that starts or ends the check phase. They also assume `frame_wide` changes only between messages, while the accumulators are cleared. The bench pulses each strobe for one cycle from the falling edge. It places `next_req` on a cycle of its own before the data frame it follows, and it toggles the format only while `crc_en` is low.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
   typedef enum logic {
      FMT_NARROW = 1'b0,
      FMT_WIDE   = 1'b1
   } frame_fmt_e;

   localparam int unsigned CHAN_TX  = 0;
   localparam int unsigned CHAN_RX  = 1;
   localparam int unsigned NUM_CHAN = 2;
endpackage

// File: rtl/spi_crc_fold.sv
module spi_crc_fold #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] crc_in,
   input  logic [W-1:0] data_in,
   input  logic [W-1:0] poly_in,
   output logic [W-1:0] crc_out
);
   initial begin
      if (W < 2) $error("spi_crc_fold: W must be at least 2");
   end

   always_comb begin
      logic [W-1:0] acc;
      logic         fb;
      acc = crc_in;
      for (int i = W - 1; i >= 0; i--) begin
         fb  = acc[W-1] ^ data_in[i];
         acc = {acc[W-2:0], 1'b0};
         if (fb) acc = acc ^ poly_in;
      end
      crc_out = acc;
   end
endmodule

// File: rtl/spi_crc_chan.sv
module spi_crc_chan #(
   parameter int unsigned WIDE_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wide,
   input  logic              upd,
   input  logic [WIDE_W-1:0] data,
   input  logic [WIDE_W-1:0] poly,
   output logic [WIDE_W-1:0] crc
);
   localparam int unsigned PAD_W = WIDE_W - NARROW_W;

   logic [WIDE_W-1:0]   crc_q;
   logic [WIDE_W-1:0]   wide_nxt;
   logic [NARROW_W-1:0] narrow_nxt;
   logic [WIDE_W-1:0]   sel_nxt;

   spi_crc_fold #(.W(WIDE_W)) u_fold_wide (
      .crc_in (crc_q),
      .data_in(data),
      .poly_in(poly),
      .crc_out(wide_nxt)
   );

   spi_crc_fold #(.W(NARROW_W)) u_fold_narrow (
      .crc_in (crc_q[NARROW_W-1:0]),
      .data_in(data[NARROW_W-1:0]),
      .poly_in(poly[NARROW_W-1:0]),
      .crc_out(narrow_nxt)
   );

   assign sel_nxt = wide ? wide_nxt : {{PAD_W{1'b0}}, narrow_nxt};

   always_ff @(posedge clk) begin
      if (!rst_n)      crc_q <= '0;
      else if (!en)    crc_q <= '0;
      else if (upd)    crc_q <= sel_nxt;
   end

   assign crc = crc_q;
endmodule

// File: rtl/spi_crc_ctrl.sv
module spi_crc_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic next_req,
   input  logic tx_done,
   input  logic rx_done,
   input  logic rx_match,
   input  logic stat_wr,
   input  logic stat_wdata,
   output logic tx_upd,
   output logic rx_upd,
   output logic crc_next,
   output logic crc_phase,
   output logic crc_err
);
   logic next_q, phase_q, err_q;
   logic err_set, err_clr;

   assign tx_upd = tx_done && !phase_q;
   assign rx_upd = rx_done && !phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (!en) begin
         next_q  <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         if (tx_done && phase_q) begin
            phase_q <= 1'b0;
            next_q  <= next_req;
         end else begin
            if (tx_done && next_q) phase_q <= 1'b1;
            if (next_req)          next_q  <= 1'b1;
         end
      end
   end

   assign err_set = en && rx_done && phase_q && !rx_match;
   assign err_clr = stat_wr && !stat_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
   end

   assign crc_next  = next_q;
   assign crc_phase = phase_q;
   assign crc_err   = err_q;
endmodule

// File: rtl/spi_crc_engine.sv
module spi_crc_engine #(
   parameter int unsigned WIDE_W     = 16,
   parameter int unsigned NARROW_W   = 8,
   parameter logic [15:0] POLY_RESET = 16'h0007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              crc_en,
   input  logic              frame_wide,
   input  logic              poly_wr,
   input  logic [WIDE_W-1:0] poly_wdata,
   input  logic              next_req,
   input  logic              tx_done,
   input  logic [WIDE_W-1:0] tx_data,
   input  logic              rx_done,
   input  logic [WIDE_W-1:0] rx_data,
   input  logic              stat_wr,
   input  logic              stat_wdata,
   output logic [WIDE_W-1:0] poly,
   output logic [WIDE_W-1:0] tx_crc,
   output logic [WIDE_W-1:0] rx_crc,
   output logic              crc_next,
   output logic              crc_phase,
   output logic              crc_err
);
   import spi_crc_pkg::*;

   localparam int unsigned PAD_W = WIDE_W - NARROW_W;

   generate
      if (NARROW_W >= WIDE_W) begin : g_bad_width
         initial $error("spi_crc_engine: NARROW_W must be below WIDE_W");
      end
      if (WIDE_W > 16) begin : g_bad_reset
         initial $error("spi_crc_engine: POLY_RESET is 16 bits wide");
      end
   endgenerate

   frame_fmt_e fmt;
   assign fmt = frame_fmt_e'(frame_wide);

   logic [WIDE_W-1:0] poly_q;
   always_ff @(posedge clk) begin
      if (!rst_n)       poly_q <= WIDE_W'(POLY_RESET);
      else if (poly_wr) poly_q <= poly_wdata;
   end
   assign poly = poly_q;

   logic tx_upd, rx_upd, rx_match;

   logic [NUM_CHAN-1:0]             upd_v;
   logic [NUM_CHAN-1:0][WIDE_W-1:0] data_v;
   logic [NUM_CHAN-1:0][WIDE_W-1:0] crc_v;

   assign upd_v[CHAN_TX]  = tx_upd;
   assign upd_v[CHAN_RX]  = rx_upd;
   assign data_v[CHAN_TX] = tx_data;
   assign data_v[CHAN_RX] = rx_data;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      spi_crc_chan #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (crc_en),
         .wide (fmt == FMT_WIDE),
         .upd  (upd_v[c]),
         .data (data_v[c]),
         .poly (poly_q),
         .crc  (crc_v[c])
      );
   end

   assign tx_crc = crc_v[CHAN_TX];
   assign rx_crc = crc_v[CHAN_RX];

   assign rx_match = (fmt == FMT_WIDE)
                   ? (rx_data == crc_v[CHAN_RX])
                   : (rx_data[NARROW_W-1:0] == crc_v[CHAN_RX][NARROW_W-1:0]);

   logic unused_pad;
   assign unused_pad = ^{PAD_W{1'b0}};

   spi_crc_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (crc_en),
      .next_req  (next_req),
      .tx_done   (tx_done),
      .rx_done   (rx_done),
      .rx_match  (rx_match),
      .stat_wr   (stat_wr),
      .stat_wdata(stat_wdata),
      .tx_upd    (tx_upd),
      .rx_upd    (rx_upd),
      .crc_next  (crc_next),
      .crc_phase (crc_phase),
      .crc_err   (crc_err)
   );
endmodule

// File: rtl/spi_crc_engine_chk.sv
module spi_crc_engine_chk #(
   parameter int unsigned WIDE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              crc_en,
   input logic              tx_done,
   input logic              rx_done,
   input logic              stat_wr,
   input logic              stat_wdata,
   input logic [WIDE_W-1:0] tx_crc,
   input logic [WIDE_W-1:0] rx_crc,
   input logic              crc_next,
   input logic              crc_phase,
   input logic              crc_err
);
   AST_TX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_en && !tx_done) |=> $stable(tx_crc)); // R2
   AST_RX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_en && !rx_done) |=> $stable(rx_crc)); // R2
   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_en |=> (tx_crc == '0 && rx_crc == '0)); // R5
   AST_PHASE_NEEDS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      crc_phase |-> crc_next); // R6
   AST_TX_HELD_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_en && crc_phase && tx_done) |=> $stable(tx_crc)); // R6
   AST_PHASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_en && crc_phase && tx_done) |=> !crc_phase); // R7
   AST_RX_HELD_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_en && crc_phase && rx_done) |=> $stable(rx_crc)); // R8
   AST_ERR_ONLY_ON_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> $past(crc_phase && rx_done)); // R8
   AST_ERR_KEEP_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err && stat_wr && stat_wdata) |=> crc_err); // R9
endmodule

bind spi_crc_engine spi_crc_engine_chk #(.WIDE_W(WIDE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .crc_en    (crc_en),
   .tx_done   (tx_done),
   .rx_done   (rx_done),
   .stat_wr   (stat_wr),
   .stat_wdata(stat_wdata),
   .tx_crc    (tx_crc),
   .rx_crc    (rx_crc),
   .crc_next  (crc_next),
   .crc_phase (crc_phase),
   .crc_err   (crc_err)
);

// File: tb/spi_crc_engine_bench.sv
module spi_crc_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic        clk = 1'b0;
   logic        rst_n, crc_en, frame_wide, poly_wr, next_req;
   logic        tx_done, rx_done, stat_wr, stat_wdata;
   logic [15:0] poly_wdata, tx_data, rx_data;
   logic [15:0] poly, tx_crc, rx_crc;
   logic        crc_next, crc_phase, crc_err;

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_poly, exp_tx, exp_rx;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_crc_engine u_spi_crc_engine (
      .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .frame_wide(frame_wide),
      .poly_wr(poly_wr), .poly_wdata(poly_wdata), .next_req(next_req),
      .tx_done(tx_done), .tx_data(tx_data), .rx_done(rx_done), .rx_data(rx_data),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .poly(poly), .tx_crc(tx_crc),
      .rx_crc(rx_crc), .crc_next(crc_next), .crc_phase(crc_phase), .crc_err(crc_err)
   );

   function automatic logic [15:0] model(input logic [15:0] c, input logic [15:0] d,
                                         input logic [15:0] p, input bit wide);
      int w;
      logic [15:0] m;
      logic fb;
      w = wide ? 16 : 8;
      m = wide ? 16'hFFFF : 16'h00FF;
      c = c & m;
      for (int i = w - 1; i >= 0; i--) begin
         fb = c[w-1] ^ d[i];
         c  = (c << 1) & m;
         if (fb) c = c ^ (p & m);
      end
      return c;
   endfunction

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic frame(input bit t, input bit r, input logic [15:0] td, input logic [15:0] rd);
      @(negedge clk);
      tx_done = t; rx_done = r; tx_data = td; rx_data = rd;
      @(negedge clk);
      tx_done = 1'b0; rx_done = 1'b0;
   endtask

   task automatic restart(input bit wide);
      @(negedge clk); crc_en = 1'b0; frame_wide = wide;
      @(negedge clk); crc_en = 1'b1;
      exp_tx = '0; exp_rx = '0;
   endtask

   task automatic t_reset;
      chk("R1 poly reset", poly, 16'h0007);
      chk("R5 tx reset", tx_crc, 16'h0);
      chk("R5 rx reset", rx_crc, 16'h0);
      chk("R9 err reset", {15'b0, crc_err}, 16'h0);
      chk("R6 next reset", {14'b0, crc_next, crc_phase}, 16'h0);
   endtask

   task automatic t_narrow_frames;
      logic [15:0] d [3] = '{16'h00A5, 16'h003C, 16'h00FF};
      restart(1'b0);
      foreach (d[i]) begin
         frame(1'b1, 1'b0, d[i], 16'h0);
         exp_tx = model(exp_tx, d[i], exp_poly, 1'b0);
         chk("R3 narrow tx fold", tx_crc, exp_tx);
         chk("R2 rx untouched by tx", rx_crc, exp_rx);
      end
      frame(1'b0, 1'b1, 16'h0, 16'h0081);
      exp_rx = model(exp_rx, 16'h0081, exp_poly, 1'b0);
      chk("R2 rx fold", rx_crc, exp_rx);
      chk("R2 tx untouched by rx", tx_crc, exp_tx);
   endtask

   task automatic t_wide_frames;
      @(negedge clk); poly_wr = 1'b1; poly_wdata = 16'h1021;
      @(negedge clk); poly_wr = 1'b0; exp_poly = 16'h1021;
      chk("R1 poly load", poly, exp_poly);
      restart(1'b1);
      frame(1'b1, 1'b1, 16'hBEEF, 16'h1234);
      exp_tx = model(exp_tx, 16'hBEEF, exp_poly, 1'b1);
      exp_rx = model(exp_rx, 16'h1234, exp_poly, 1'b1);
      chk("R4 wide tx fold", tx_crc, exp_tx);
      chk("R4 wide rx fold", rx_crc, exp_rx);
      frame(1'b1, 1'b0, 16'h8001, 16'h0);
      exp_tx = model(exp_tx, 16'h8001, exp_poly, 1'b1);
      chk("R3 wide second frame", tx_crc, exp_tx);
   endtask

   task automatic t_narrow_upper;
      restart(1'b0);
      frame(1'b1, 1'b0, 16'hFFC3, 16'h0);
      exp_tx = model(16'h0, 16'h00C3, exp_poly & 16'h00FF, 1'b0);
      chk("R4 narrow ignores upper data and poly", tx_crc, exp_tx);
      chk("R4 narrow upper byte zero", tx_crc & 16'hFF00, 16'h0);
   endtask

   task automatic t_disable;
      restart(1'b1);
      frame(1'b1, 1'b1, 16'h5A5A, 16'hA5A5);
      @(negedge clk); crc_en = 1'b0;
      @(negedge clk);
      chk("R5 disable clears tx", tx_crc, 16'h0);
      chk("R5 disable clears rx", rx_crc, 16'h0);
      frame(1'b1, 1'b1, 16'h1111, 16'h2222);
      chk("R5 strobe ignored while disabled", tx_crc | rx_crc, 16'h0);
      @(negedge clk); crc_en = 1'b1;
   endtask

   task automatic t_append(input bit bad);
      logic [15:0] held_tx;
      restart(1'b0);
      frame(1'b1, 1'b1, 16'h0031, 16'h0031);
      exp_tx = model(exp_tx, 16'h0031, exp_poly, 1'b0);
      exp_rx = exp_tx;
      @(negedge clk); next_req = 1'b1;
      @(negedge clk); next_req = 1'b0;
      chk("R6 request pending", {15'b0, crc_next}, 16'h1);
      chk("R6 no phase before data frame", {15'b0, crc_phase}, 16'h0);
      frame(1'b1, 1'b1, 16'h0077, 16'h0077);
      exp_tx = model(exp_tx, 16'h0077, exp_poly, 1'b0);
      exp_rx = exp_tx;
      chk("R6 last data frame folded", tx_crc, exp_tx);
      chk("R6 phase entered", {14'b0, crc_next, crc_phase}, 16'h3);
      held_tx = tx_crc;
      frame(1'b1, 1'b1, held_tx, bad ? (exp_rx ^ 16'h0001) : exp_rx);
      chk("R6 tx held over check frame", tx_crc, exp_tx);
      chk("R8 rx held over check frame", rx_crc, exp_rx);
      chk("R7 phase and request cleared", {14'b0, crc_next, crc_phase}, 16'h0);
      chk(bad ? "R8 mismatch raises error" : "R8 match leaves error low",
          {15'b0, crc_err}, bad ? 16'h1 : 16'h0);
   endtask

   task automatic t_err_clear;
      @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b1;
      @(negedge clk); stat_wr = 1'b0;
      chk("R9 write one keeps error", {15'b0, crc_err}, 16'h1);
      @(negedge clk); stat_wr = 1'b1; stat_wdata = 1'b0;
      @(negedge clk); stat_wr = 1'b0;
      chk("R9 write zero clears error", {15'b0, crc_err}, 16'h0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; crc_en = 1'b0; frame_wide = 1'b0; poly_wr = 1'b0;
      poly_wdata = '0; next_req = 1'b0; tx_done = 1'b0; rx_done = 1'b0;
      tx_data = '0; rx_data = '0; stat_wr = 1'b0; stat_wdata = 1'b0;
      exp_poly = 16'h0007; exp_tx = '0; exp_rx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_narrow_frames();
      t_append(1'b0);
      t_append(1'b1);
      t_err_clear();
      t_wide_frames();
      t_narrow_upper();
      t_disable();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule